// File: doc/BRIEF.md
# Disk Sector Address Sequencer

This block keeps the cylinder, head and sector address of a floppy-style sector transfer, and moves that address forward each time the data path reports that a whole sector is finished. A single load strobe captures a new command. That command gives the starting track, head and sector, the sectors per track, the sector at which the command ends, whether the medium has two sides, and whether the command may cross from one head to the other. The same strobe starts a byte count. The count is either worked out from the sector size code and the number of sectors, or taken directly from a short length byte.

While a transfer is running, a per-byte strobe counts the remaining bytes down. A one-cycle terminate strobe tells the surrounding controller to end the command. It fires when the address runs off the end of what the command allows, or when the byte count reaches zero. After the strobe the block is idle, and it ignores sector and byte strobes until the next load.

Top module: `sector_seq`

## Requirements
- R1: After a synchronous active-high reset: sector is 1, track is 0, head is 0, remaining bytes is 0, the terminate strobe is low, and the block is idle.
- R2: A load captures the start track, head and sector, and starts the transfer. For a size code N other than 0, remaining bytes becomes (128 << N) × (last − start + 1), where last is the sectors-per-track value.
- R3: When a load has multi-track mode set and a size code other than 0, the sector count used for the length is increased by the sectors-per-track value.
- R4: A load with size code 0 sets remaining bytes to the length byte, whatever the sector values are.
- R5: A size code above 7 is treated as 7, so the bytes per sector never exceed 16384.
- R6: On a sector-done strobe during a transfer, if the current sector is below the sectors-per-track value and differs from the end sector, the sector increases by one. Track and head are unchanged, and no terminate strobe is produced.
- R7: A sector-done strobe when the current sector equals the end sector wraps the sector to 1, even if that is earlier than the last sector on the track.
- R8: A wrap with multi-track mode off increments the track, leaves the head unchanged and produces the terminate strobe.
- R9: A wrap in multi-track mode on a double-sided medium from head 0 moves to head 1 on the same track. The transfer continues.
- R10: A wrap in multi-track mode from head 1 sets head 0 and increments the track. The transfer continues on a double-sided medium. On a single-sided medium the wrap sets head 0, increments the track and terminates.
- R11: Each byte strobe during a transfer with a nonzero count lowers remaining bytes by one. The strobe that brings the count to 0 produces the terminate strobe.
- R12: The terminate strobe lasts exactly one cycle. Afterwards, and before any load, sector-done and byte strobes leave the address and the count unchanged. A load in the same cycle as a sector-done strobe takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture a new command and start a transfer |
| ld_track | input | TRK_W | Starting track |
| ld_head | input | 1 | Starting head |
| ld_sector | input | SEC_W | Starting sector (1-based) |
| ld_last | input | SEC_W | Sectors per track |
| ld_end | input | SEC_W | End sector of the command |
| ld_size | input | 8 | Sector size code |
| ld_len | input | 8 | Byte length used when the size code is 0 |
| ld_dual | input | 1 | Medium is double-sided |
| ld_multi | input | 1 | Multi-track mode |
| sector_done | input | 1 | One sector finished |
| byte_ack | input | 1 | One byte moved |
| cur_track | output | TRK_W | Current track |
| cur_head | output | 1 | Current head |
| cur_sector | output | SEC_W | Current sector |
| remaining | output | LEN_W | Bytes left in the transfer |
| term | output | 1 | One-cycle terminate strobe |

## Verification
The length calculation is tried with four kinds of load:
- a plain size code, which shows that the shift and the sector-count subtraction are right;
- the same code with multi-track mode set, which exposes a missing extra track;
- size code 0, which separates the raw length byte from the computed path;
- an oversized code, which catches a missing clamp.

The address stepping is driven through three wraps:
- an early wrap at the end sector with single-track mode, which must step the track and stop;
- a wrap at the last sector on a double-sided medium, followed by a second wrap from head 1;
- a single-sided multi-track wrap.

Together these three wraps tell apart the head flip, the track step and the termination decision. Strobes given after termination, and a load given together with a sector-done strobe, show that an idle block holds its state and that a load takes priority.

// File: rtl/sector_seq.sv
module sector_seq #(
  parameter int TRK_W = 8,
  parameter int SEC_W = 8,
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TRK_W-1:0] ld_track,
  input  logic             ld_head,
  input  logic [SEC_W-1:0] ld_sector,
  input  logic [SEC_W-1:0] ld_last,
  input  logic [SEC_W-1:0] ld_end,
  input  logic [7:0]       ld_size,
  input  logic [7:0]       ld_len,
  input  logic             ld_dual,
  input  logic             ld_multi,
  input  logic             sector_done,
  input  logic             byte_ack,
  output logic [TRK_W-1:0] cur_track,
  output logic             cur_head,
  output logic [SEC_W-1:0] cur_sector,
  output logic [LEN_W-1:0] remaining,
  output logic             term
);
  localparam int CNT_W = SEC_W + 2;

  logic             active, multi, dual;
  logic [SEC_W-1:0] last_s, end_s;

  logic [2:0]       shift;
  logic [CNT_W-1:0] nsect;
  logic [LEN_W-1:0] bps, calc_len;
  logic             wrap, step, count;
  logic             stop_sec, stop_cnt;

  assign shift    = (ld_size > 8'd7) ? 3'd7 : ld_size[2:0];
  assign bps      = LEN_W'(128) << shift;
  assign nsect    = CNT_W'(ld_last) - CNT_W'(ld_sector) + CNT_W'(1)
                  + (ld_multi ? CNT_W'(ld_last) : CNT_W'(0));
  assign calc_len = (ld_size == 8'd0) ? LEN_W'(ld_len) : LEN_W'(bps * LEN_W'(nsect));

  assign step     = active && !load && sector_done;
  assign count    = active && !load && byte_ack && remaining != '0;
  assign wrap     = (cur_sector >= last_s) || (cur_sector == end_s);
  assign stop_sec = step && wrap && !(multi && dual);
  assign stop_cnt = count && remaining == LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      multi      <= 1'b0;
      dual       <= 1'b0;
      last_s     <= '0;
      end_s      <= '0;
      cur_track  <= '0;
      cur_head   <= 1'b0;
      cur_sector <= SEC_W'(1);
      remaining  <= '0;
      term       <= 1'b0;
    end else begin
      term <= stop_sec || stop_cnt;
      if (load) begin
        active     <= 1'b1;
        multi      <= ld_multi;
        dual       <= ld_dual;
        last_s     <= ld_last;
        end_s      <= ld_end;
        cur_track  <= ld_track;
        cur_head   <= ld_head;
        cur_sector <= ld_sector;
        remaining  <= calc_len;
      end else begin
        if (stop_sec || stop_cnt) active <= 1'b0;
        if (count) remaining <= remaining - LEN_W'(1);
        if (step) begin
          if (!wrap) begin
            cur_sector <= cur_sector + SEC_W'(1);
          end else begin
            cur_sector <= SEC_W'(1);
            if (multi && dual && !cur_head) begin
              cur_head <= 1'b1;
            end else begin
              if (multi) cur_head <= 1'b0;
              cur_track <= cur_track + TRK_W'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sector_seq_checker.sv
module sector_seq_checker #(
  parameter int TRK_W = 8,
  parameter int SEC_W = 8,
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             sector_done,
  input logic             byte_ack,
  input logic             active,
  input logic [TRK_W-1:0] cur_track,
  input logic             cur_head,
  input logic [SEC_W-1:0] cur_sector,
  input logic [LEN_W-1:0] remaining,
  input logic             term
);
  a_r12_term_one_cycle: assert property (@(posedge clk) disable iff (rst)
    term |=> !term);

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!active && !load) |=> ($stable(cur_track) && $stable(cur_head)
                            && $stable(cur_sector) && $stable(remaining)));

  a_r11_count_down: assert property (@(posedge clk) disable iff (rst)
    (active && !load && byte_ack && remaining != '0)
      |=> remaining == $past(remaining) - LEN_W'(1));

  a_r6_sector_step: assert property (@(posedge clk) disable iff (rst)
    (active && !load && sector_done)
      |=> (cur_sector == SEC_W'(1) || cur_sector == $past(cur_sector) + SEC_W'(1)));

  a_r6_no_step_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !sector_done)
      |=> ($stable(cur_track) && $stable(cur_head) && $stable(cur_sector)));

  a_r8_term_clears_active: assert property (@(posedge clk) disable iff (rst)
    (term && !load) |-> !active);
endmodule

bind sector_seq sector_seq_checker #(.TRK_W(TRK_W), .SEC_W(SEC_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .sector_done(sector_done), .byte_ack(byte_ack),
  .active(active), .cur_track(cur_track), .cur_head(cur_head),
  .cur_sector(cur_sector), .remaining(remaining), .term(term)
);

// File: tb/sector_seq_bench.sv
module sector_seq_bench;
  logic        clk = 1'b0;
  logic        rst, load, ld_head, ld_dual, ld_multi, sector_done, byte_ack;
  logic [7:0]  ld_track, ld_sector, ld_last, ld_end, ld_size, ld_len;
  logic [7:0]  cur_track, cur_sector;
  logic        cur_head, term;
  logic [23:0] remaining;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sector_seq u_sector_seq (
    .clk(clk), .rst(rst), .load(load), .ld_track(ld_track), .ld_head(ld_head),
    .ld_sector(ld_sector), .ld_last(ld_last), .ld_end(ld_end), .ld_size(ld_size),
    .ld_len(ld_len), .ld_dual(ld_dual), .ld_multi(ld_multi),
    .sector_done(sector_done), .byte_ack(byte_ack), .cur_track(cur_track),
    .cur_head(cur_head), .cur_sector(cur_sector), .remaining(remaining), .term(term)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_addr(string req, int trk, int hd, int sec, int t);
    chk({req, " track"}, cur_track, trk);
    chk({req, " head"}, cur_head, hd);
    chk({req, " sector"}, cur_sector, sec);
    chk({req, " term"}, term, t);
  endtask

  task automatic do_load(int trk, int hd, int sec, int last, int eot,
                         int sz, int len, int dual, int multi, int with_step);
    @(negedge clk);
    load = 1; ld_track = 8'(trk); ld_head = 1'(hd); ld_sector = 8'(sec);
    ld_last = 8'(last); ld_end = 8'(eot); ld_size = 8'(sz); ld_len = 8'(len);
    ld_dual = 1'(dual); ld_multi = 1'(multi); sector_done = 1'(with_step);
    @(negedge clk);
    load = 0; sector_done = 0;
  endtask

  task automatic step_sec();
    @(negedge clk); sector_done = 1;
    @(negedge clk); sector_done = 0;
  endtask

  task automatic ack();
    @(negedge clk); byte_ack = 1;
    @(negedge clk); byte_ack = 0;
  endtask

  task automatic t_reset();
    rst = 1; load = 0; sector_done = 0; byte_ack = 0;
    ld_track = 0; ld_head = 0; ld_sector = 0; ld_last = 0; ld_end = 0;
    ld_size = 0; ld_len = 0; ld_dual = 0; ld_multi = 0;
    repeat (3) @(negedge clk);
    chk_addr("R1", 0, 0, 1, 0);
    chk("R1 remaining", remaining, 0);
    rst = 0;
    step_sec(); ack();
    chk_addr("R12 idle after reset", 0, 0, 1, 0);
    chk("R12 idle count", remaining, 0);
  endtask

  task automatic t_length();
    do_load(5, 0, 3, 9, 9, 2, 0, 1, 0, 0);
    chk_addr("R2 load", 5, 0, 3, 0);
    chk("R2 length", remaining, 512 * 7);
    step_sec();
    chk_addr("R6 increment", 5, 0, 4, 0);
    ack(); ack();
    chk("R11 count down", remaining, 3582);
    do_load(0, 0, 4, 8, 8, 1, 0, 1, 1, 0);
    chk("R3 multi length", remaining, 256 * 13);
    do_load(0, 0, 1, 1, 1, 9, 0, 1, 0, 0);
    chk("R5 clamp", remaining, 16384);
    do_load(0, 0, 2, 9, 9, 0, 128, 1, 1, 0);
    chk("R4 raw length", remaining, 128);
  endtask

  task automatic t_end_wrap();
    do_load(2, 1, 5, 18, 6, 2, 0, 1, 0, 0);
    step_sec();
    chk_addr("R6 step to end", 2, 1, 6, 0);
    step_sec();
    chk_addr("R7 R8 end wrap", 3, 1, 1, 1);
    @(negedge clk);
    chk("R12 term one cycle", term, 0);
    step_sec(); ack();
    chk_addr("R12 ignored after term", 3, 1, 1, 0);
    chk("R12 count held", remaining, 512 * 14);
  endtask

  task automatic t_multi_dual();
    do_load(7, 0, 9, 9, 20, 2, 0, 1, 1, 0);
    step_sec();
    chk_addr("R9 head flip", 7, 1, 1, 0);
    for (int i = 0; i < 8; i++) step_sec();
    chk_addr("R6 head1 steps", 7, 1, 9, 0);
    step_sec();
    chk_addr("R10 head1 wrap", 8, 0, 1, 0);
    step_sec();
    chk_addr("R10 continues", 8, 0, 2, 0);
  endtask

  task automatic t_multi_single();
    do_load(0, 0, 4, 4, 4, 2, 0, 0, 1, 0);
    step_sec();
    chk_addr("R10 single-sided stop", 1, 0, 1, 1);
  endtask

  task automatic t_bytes();
    do_load(0, 0, 1, 9, 9, 0, 3, 1, 0, 0);
    ack(); ack();
    chk("R11 count", remaining, 1);
    chk("R11 no early term", term, 0);
    ack();
    chk("R11 zero", remaining, 0);
    chk("R11 term", term, 1);
    ack();
    chk("R12 stays zero", remaining, 0);
    chk("R12 no repeat term", term, 0);
  endtask

  task automatic t_priority();
    do_load(4, 0, 2, 9, 9, 2, 0, 1, 0, 0);
    do_load(6, 1, 3, 9, 9, 2, 0, 1, 0, 1);
    chk_addr("R12 load priority", 6, 1, 3, 0);
    chk("R12 load priority len", remaining, 512 * 7);
  endtask

  initial begin
    t_reset();
    t_length();
    t_end_wrap();
    t_multi_dual();
    t_multi_single();
    t_bytes();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule